// File: doc/BRIEF.md
# Cascaded ADC Word Aligner

This block sits on the receive side of a serial link fed by one or more cascaded six-channel converters. Each converter sends its result words on a shared serial line, and a frame sync pulse marks every single word. No pulse marks the start of a complete set of channels. The block oversamples the serial clock, data, frame sync and serial-enable lines with the system clock. It rebuilds each 16-bit word and tags it with the converter it came from and the channel it carries.

Framing comes from three sources. A rising serial-enable restarts the position counters. The per-word sync delimits the bits of each word. An idle interval longer than a programmed number of system cycles forces the counters back to the start of a set. If that idle interval arrives part-way through a set, bits were lost or gained, and a sticky flag is raised. A frame sync that cuts a word short drops the partial word and is counted.

Top module: `adc_chain_aligner`

## Requirements
- R1: After reset, `word_valid`, `misalign` and `frag_err_cnt` are all zero.
- R2: A word is 16 bits, most significant bit first. Each bit is sampled on the falling edge of `ser_clk`. A word begins at the bit whose falling edge sees `ser_fs` high.
- R3: Each completed word produces exactly one `word_valid` pulse of one cycle. The pulse carries the received bits on `word_data`, with `word_dev` and `word_ch` tags.
- R4: Device index 0 is the converter nearest the receiver. Within one channel slot, words are tagged from device NUM_DEV-1 down to device 0. After device 0 the channel index increments, and after channel index 5 with device 0 the next word is channel 0 of device NUM_DEV-1.
- R5: A rising edge on `ser_en` restarts the tags, so the next word is channel 0 of device NUM_DEV-1.
- R6: While `ser_en` is low, no word is produced, and idle time raises no misalignment.
- R7: When no word is in progress for `gap_limit` consecutive system cycles with `ser_en` high, the tags return to channel 0 of device NUM_DEV-1.
- R8: The idle interval of R7 sets `misalign` if it comes when the tags are not at the start of a set. It leaves `misalign` unchanged if it comes exactly at a set boundary.
- R9: Once set, `misalign` stays high until `misalign_clr` is pulsed, and it is low in the cycle after the clear.
- R10: A frame sync arriving before 16 bits of a word are in discards that partial word and increments `frag_err_cnt`, which saturates. The discarded word does not advance the tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the converter chain |
| ser_data | input | 1 | Serial data from the converter chain |
| ser_fs | input | 1 | Per-word frame sync |
| ser_en | input | 1 | Serial-enable line driven to the converters |
| gap_limit | input | GAP_W | Idle system cycles that mark the end of a set |
| misalign_clr | input | 1 | Clears the sticky misalignment flag |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | WORD_W | Received word |
| word_dev | output | DEV_W | Device index of the word |
| word_ch | output | CH_W | Channel index of the word (0 to 5) |
| misalign | output | 1 | Sticky misalignment flag |
| frag_err_cnt | output | ERR_W | Saturating count of discarded partial words |

## Verification
The bound checker tests these properties on every cycle:
- every strobe carries tags in range;
- strobes never come back to back;
- no strobe appears while serial-enable has been low;
- the misalignment flag holds until cleared and rises only after a mid-set idle interval;
- the fragment counter never decreases.

Only the bench scenarios can show that the tag order follows the chain position, and that the tags restart on serial-enable and after a gap. They also show that a truncated word is dropped without disturbing the order, and that data bits come out in the right order for several patterns.

// File: rtl/adc_align_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the cascaded ADC word aligner.
package adc_align_pkg;
    localparam int CH_PER_DEV = 6;

    // Width of an index over n items, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/aln_sync.sv
`timescale 1ns/1ps
// aln_sync: two-flop synchronizer, one chain per input bit.
// Assumes each input is asynchronous to clk and stays stable for several clk periods.
module aln_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] st;
        // Shift the asynchronous bit through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) st <= 2'b00;
            else        st <= {st[0], d[g]};
        end
        assign q[g] = st[1];
    end
endmodule

// File: rtl/aln_deser.sv
`timescale 1ns/1ps
// aln_deser: rebuilds words from the synchronized serial lines.
// Samples data on falling serial-clock edges. A frame sync on a bit starts a word.
// A sync that arrives mid-word discards the partial word and pulses frag.
// Assumes the serial clock is well below clk/4.
module aln_deser #(
    parameter int WORD_W = 16,
    localparam int BCNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              fs_s,
    input  logic              en_s,
    output logic              done,
    output logic [WORD_W-1:0] data,
    output logic              busy,
    output logic              frag
);
    logic              sclk_d;
    logic              fall;
    logic [BCNT_W-1:0] bcnt;
    logic [WORD_W-2:0] shreg;

    assign fall = sclk_d & ~sclk_s;
    assign busy = (bcnt != '0);

    // Bit counting, shifting and word completion on each sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            bcnt   <= '0;
            shreg  <= '0;
            data   <= '0;
            done   <= 1'b0;
            frag   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            done   <= 1'b0;
            frag   <= 1'b0;
            if (!en_s) begin
                bcnt <= '0;
            end else if (fall) begin
                if (fs_s) begin
                    frag  <= busy;
                    shreg <= {{(WORD_W-2){1'b0}}, sdata_s};
                    bcnt  <= BCNT_W'(1);
                end else if (busy) begin
                    shreg <= {shreg[WORD_W-3:0], sdata_s};
                    if (bcnt == BCNT_W'(WORD_W-1)) begin
                        data <= {shreg, sdata_s};
                        done <= 1'b1;
                        bcnt <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/aln_slot_ctr.sv
`timescale 1ns/1ps
// aln_slot_ctr: device/channel position counters, idle-gap detector, sticky flag.
// The position restarts on a serial-enable rise or on an idle gap.
// A gap seen away from the start of a set raises the misalignment flag.
module aln_slot_ctr #(
    parameter int NUM_DEV    = 2,
    parameter int CH_PER_DEV = 6,
    parameter int GAP_W      = 16,
    localparam int DEV_W = adc_align_pkg::idx_w(NUM_DEV),
    localparam int CH_W  = adc_align_pkg::idx_w(CH_PER_DEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             done,
    input  logic             busy,
    input  logic [GAP_W-1:0] gap_limit,
    input  logic             mis_clr,
    output logic [DEV_W-1:0] dev,
    output logic [CH_W-1:0]  ch,
    output logic             at_start,
    output logic             gap_hit,
    output logic             misalign
);
    localparam logic [DEV_W-1:0] DEV_FAR  = DEV_W'(NUM_DEV-1);
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CH_PER_DEV-1);

    logic             en_d;
    logic             en_rise;
    logic [GAP_W-1:0] idle;

    assign en_rise  = en_s & ~en_d;
    assign at_start = (dev == DEV_FAR) && (ch == '0);
    assign gap_hit  = en_s & ~en_rise & ~busy & ~done & (idle == gap_limit);

    // Idle time since the last word ended, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0;
            idle <= '0;
        end else begin
            en_d <= en_s;
            if (!en_s || en_rise || busy || done) idle <= '0;
            else if (idle != '1)                  idle <= idle + 1'b1;
        end
    end

    // Position in the set: far device first, then the channel steps.
    always_ff @(posedge clk) begin
        if (!rst_n || en_rise || gap_hit) begin
            dev <= DEV_FAR;
            ch  <= '0;
        end else if (done) begin
            if (dev == '0) begin
                dev <= DEV_FAR;
                ch  <= (ch == CH_LAST) ? '0 : ch + 1'b1;
            end else begin
                dev <= dev - 1'b1;
            end
        end
    end

    // Sticky misalignment flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)                     misalign <= 1'b0;
        else if (gap_hit && !at_start)  misalign <= 1'b1;
        else if (mis_clr)               misalign <= 1'b0;
    end
endmodule

// File: rtl/adc_chain_aligner.sv
`timescale 1ns/1ps
// adc_chain_aligner: top of the cascaded ADC word aligner.
// Synchronizes the serial lines, rebuilds words, tags them with device and channel,
// and counts truncated words. Outputs are registered. No backpressure.
module adc_chain_aligner #(
    parameter int NUM_DEV = 2,
    parameter int WORD_W  = 16,
    parameter int GAP_W   = 16,
    parameter int ERR_W   = 8,
    localparam int DEV_W = adc_align_pkg::idx_w(NUM_DEV),
    localparam int CH_W  = adc_align_pkg::idx_w(adc_align_pkg::CH_PER_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_fs,
    input  logic              ser_en,
    input  logic [GAP_W-1:0]  gap_limit,
    input  logic              misalign_clr,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic [DEV_W-1:0]  word_dev,
    output logic [CH_W-1:0]   word_ch,
    output logic              misalign,
    output logic [ERR_W-1:0]  frag_err_cnt
);
    logic [3:0]        sync_q;
    logic              sclk_s, sdata_s, fs_s, en_s;
    logic              done, busy, frag, at_start, gap_hit;
    logic [WORD_W-1:0] data;
    logic [DEV_W-1:0]  dev;
    logic [CH_W-1:0]   ch;

    aln_sync #(.W(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_en, ser_fs, ser_data, ser_clk}),
        .q(sync_q)
    );
    assign {en_s, fs_s, sdata_s, sclk_s} = sync_q;

    aln_deser #(.WORD_W(WORD_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdata_s(sdata_s),
        .fs_s(fs_s), .en_s(en_s), .done(done), .data(data),
        .busy(busy), .frag(frag)
    );

    aln_slot_ctr #(
        .NUM_DEV(NUM_DEV), .CH_PER_DEV(adc_align_pkg::CH_PER_DEV), .GAP_W(GAP_W)
    ) u_slot (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .done(done), .busy(busy),
        .gap_limit(gap_limit), .mis_clr(misalign_clr), .dev(dev), .ch(ch),
        .at_start(at_start), .gap_hit(gap_hit), .misalign(misalign)
    );

    // Present each completed word with the tags of its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_dev   <= '0;
            word_ch    <= '0;
        end else begin
            word_valid <= done;
            if (done) begin
                word_data <= data;
                word_dev  <= dev;
                word_ch   <= ch;
            end
        end
    end

    // Saturating count of truncated words.
    always_ff @(posedge clk) begin
        if (!rst_n)                          frag_err_cnt <= '0;
        else if (frag && frag_err_cnt != '1) frag_err_cnt <= frag_err_cnt + 1'b1;
    end
endmodule

// File: rtl/aln_chk.sv
`timescale 1ns/1ps
// aln_chk: cycle-level properties of the aligner, bound into the top module.
module aln_chk #(
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1,
    parameter int CH_W    = 3,
    parameter int ERR_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_s,
    input logic             gap_hit,
    input logic             at_start,
    input logic             word_valid,
    input logic [DEV_W-1:0] word_dev,
    input logic [CH_W-1:0]  word_ch,
    input logic             misalign,
    input logic             misalign_clr,
    input logic [ERR_W-1:0] frag_err_cnt
);
    // R4
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (int'(word_dev) < NUM_DEV) && (int'(word_ch) < adc_align_pkg::CH_PER_DEV));
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    // R6
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !$past(en_s)) |-> !word_valid);
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign && !misalign_clr) |=> misalign);
    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(misalign) |-> $past(gap_hit && !at_start));
    // R10
    frag_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> frag_err_cnt >= $past(frag_err_cnt));
endmodule

bind adc_chain_aligner aln_chk #(
    .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .CH_W(CH_W), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .gap_hit(gap_hit), .at_start(at_start),
    .word_valid(word_valid), .word_dev(word_dev), .word_ch(word_ch),
    .misalign(misalign), .misalign_clr(misalign_clr), .frag_err_cnt(frag_err_cnt)
);

// File: tb/adc_chain_aligner_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected words, the monitor compares outputs.
module adc_chain_aligner_bench;
    localparam int NUM_DEV = 2;
    localparam int DEV_W   = 1;
    localparam int CH_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_fs = 1'b0, ser_en = 1'b0;
    logic [15:0] gap_limit = 16'd60;
    logic misalign_clr = 1'b0;
    logic word_valid;
    logic [15:0] word_data;
    logic [DEV_W-1:0] word_dev;
    logic [CH_W-1:0] word_ch;
    logic misalign;
    logic [7:0] frag_err_cnt;

    int n_chk = 0, n_bad = 0;
    int m_dev = NUM_DEV - 1, m_ch = 0;
    logic [31:0] expq[$];

    always #2.5 clk = ~clk;

    adc_chain_aligner #(.NUM_DEV(NUM_DEV)) u_adc_chain_aligner (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_fs(ser_fs), .ser_en(ser_en), .gap_limit(gap_limit),
        .misalign_clr(misalign_clr), .word_valid(word_valid), .word_data(word_data),
        .word_dev(word_dev), .word_ch(word_ch), .misalign(misalign),
        .frag_err_cnt(frag_err_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_restart();
        m_dev = NUM_DEV - 1;
        m_ch  = 0;
    endtask

    // Drive nbits of d, MSB first, sync on the first bit; queue the word if complete.
    task automatic send_word(input logic [15:0] d, input int nbits, input bit expect_out);
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk); #1;
            ser_data = d[15-i];
            ser_fs   = (i == 0);
            ser_clk  = 1'b1;
            repeat (4) @(posedge clk);
            #1 ser_clk = 1'b0;
            repeat (4) @(posedge clk);
        end
        #1 ser_fs = 1'b0;
        if (expect_out && nbits == 16) begin
            expq.push_back({d, 8'(m_dev), 8'(m_ch)});
            if (m_dev == 0) begin
                m_dev = NUM_DEV - 1;
                m_ch  = (m_ch == 5) ? 0 : m_ch + 1;
            end else begin
                m_dev--;
            end
        end
        repeat (8) @(posedge clk);
    endtask

    // Monitor: R2 data order, R3 strobe, R4 tag order against the queue.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            logic [31:0] got;
            got = {word_data, 8'(word_dev), 8'(word_ch)};
            if (expq.size() == 0) chk(1'b0, "R3/R6 unexpected word", int'(got), 0);
            else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(got == e, "R2/R4 word and tags", int'(got), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(word_valid == 0, "R1 word_valid", word_valid, 0);
        chk(misalign == 0, "R1 misalign", misalign, 0);
        chk(frag_err_cnt == 0, "R1 frag_err_cnt", frag_err_cnt, 0);

        // R5 enable rise, full set: R4 order across all slots
        ser_en = 1'b1;
        repeat (10) @(posedge clk);
        model_restart();
        for (int k = 0; k < 12; k++) send_word(16'h1230 + 16'(k * 16'h0101), 16, 1'b1);
        repeat (150) @(posedge clk);
        @(negedge clk);
        // R8 gap at set boundary leaves flag low
        chk(misalign == 0, "R8 boundary gap", misalign, 0);
        model_restart();

        // R2 extreme patterns
        send_word(16'hFFFF, 16, 1'b1);
        send_word(16'h0000, 16, 1'b1);
        send_word(16'h8001, 16, 1'b1);
        send_word(16'h5A5A, 16, 1'b1);
        send_word(16'hA5C3, 16, 1'b1);
        repeat (150) @(posedge clk);
        @(negedge clk);
        // R8 mid-set gap raises flag
        chk(misalign == 1, "R8 mid-set gap", misalign, 1);
        model_restart();
        // R7 tags restart after gap
        send_word(16'h7E81, 16, 1'b1);
        send_word(16'h0F0F, 16, 1'b1);
        @(negedge clk);
        // R9 flag stays without clear
        chk(misalign == 1, "R9 sticky", misalign, 1);
        @(posedge clk); #1 misalign_clr = 1'b1;
        @(posedge clk); #1 misalign_clr = 1'b0;
        @(negedge clk);
        chk(misalign == 0, "R9 cleared", misalign, 0);

        // R10 truncated word dropped and counted, order kept
        send_word(16'hDEAD, 7, 1'b0);
        send_word(16'hBEEF, 16, 1'b1);
        @(negedge clk);
        chk(frag_err_cnt == 1, "R10 frag count", frag_err_cnt, 1);
        send_word(16'hC0DE, 16, 1'b1);

        // R6 enable low: no words, gap ignored
        @(posedge clk); #1 ser_en = 1'b0;
        repeat (10) @(posedge clk);
        send_word(16'h1111, 16, 1'b0);
        send_word(16'h2222, 16, 1'b0);
        repeat (150) @(posedge clk);
        @(negedge clk);
        chk(misalign == 0, "R6 no flag while disabled", misalign, 0);
        chk(expq.size() == 0, "R6 nothing pending", expq.size(), 0);

        // R5 enable rise restarts tags mid-set
        @(posedge clk); #1 ser_en = 1'b1;
        repeat (10) @(posedge clk);
        model_restart();
        send_word(16'h3C3C, 16, 1'b1);
        send_word(16'h4B4B, 16, 1'b1);
        send_word(16'h6969, 16, 1'b1);
        repeat (20) @(posedge clk);
        chk(expq.size() == 0, "R3 all words seen", expq.size(), 0);
        chk(frag_err_cnt == 1, "R10 count unchanged", frag_err_cnt, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule